// File: doc/BRIEF.md
# Timestamp Event Queue

The block gathers time-stamped event records from a number of sources and keeps them in a small first-in first-out store, so that software can read them at its own pace. The sources are a software push strobe, eight hardware push inputs (each one individually enabled and tagged with its own port number), and an Ethernet indication for received or transmitted precision-time packets that carries message type, sequence ID, port and domain. Every accepted event is stamped with the free-running time value present at the block's input in the cycle it is accepted.

Software sees the oldest record through four 32-bit read words (timestamp low half, packed descriptor, domain, timestamp high half) and discards it with a one-cycle pop strobe. A raw pending flag reports a non-empty queue; a masked copy and the interrupt output follow it only while the interrupt enable is set. Several sources may fire in one cycle; all of them are stored in a fixed priority order until the queue is full, after which the remainder is dropped and a sticky overflow flag is raised.

Top module: `ts_event_queue`

## Requirements
- R1: The queue holds 16 records; an event arriving while 16 records are held is not stored and the held records are unchanged.
- R2: The descriptor word carries sequence ID in bits 15:0, message type in bits 19:16, event type in bits 23:20 and port number in bits 28:24, with bits 31:29 zero.
- R3: The domain word carries the 8-bit domain in bits 7:0 with the upper bits zero; the two timestamp words carry bits 31:0 and 63:32 of the time value sampled in the cycle the event was accepted.
- R4: Event type codes are 0 software push, 1 rollover, 2 half rollover, 3 hardware push, 4 Ethernet receive, 5 Ethernet transmit, 6 compare, 7 host transmit; software and hardware pushes carry zero message type, sequence ID and domain, and software pushes carry port 0.
- R5: `pend_raw` (status bit 0) is 1 exactly while at least one record is held; a pop strobe (pop register bit 0) discards the head record, and a pop strobe on an empty queue has no effect.
- R6: Hardware input k is recorded only on a rising edge and only while enable bit k (control bits 8 to 15) is set, with port number k+1; an input held high produces one record.
- R7: `pend_masked` and `irq_o` equal `pend_raw` while `cfg_irq_en` (interrupt enable bit 0) is 1 and are 0 otherwise.
- R8: Ethernet receive indications are recorded only while `cfg_rx_ts_en` (control bit 3) is 1; transmit indications are always recorded.
- R9: `overflow_o` is 0 after reset, becomes 1 when any event is dropped for lack of space, and stays 1 until reset.
- R10: Events that fire in the same cycle are stored in the order software push, hardware inputs 0 to 7, Ethernet; when space runs out the lowest-priority ones are the ones dropped.
- R11: While the queue is empty all four read words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_now | input | 64 | Current time value used to stamp events |
| cfg_rx_ts_en | input | 1 | Receive timestamping enable (control bit 3) |
| cfg_hw_en | input | 8 | Per-input hardware push enables (control bits 8 to 15) |
| cfg_irq_en | input | 1 | Interrupt enable (enable register bit 0) |
| sw_push | input | 1 | Software push strobe |
| hw_push_in | input | 8 | Hardware push inputs, already synchronized |
| eth_valid | input | 1 | Ethernet timestamp indication |
| eth_is_tx | input | 1 | 1 for transmit, 0 for receive |
| eth_msg_type | input | 4 | Message type of the packet |
| eth_seq_id | input | 16 | Sequence ID of the packet |
| eth_port | input | 5 | Ethernet port number |
| eth_domain | input | 8 | Time domain of the packet |
| pop_strobe | input | 1 | Pop register write with bit 0 set |
| rd_ts_lo | output | 32 | Head record timestamp bits 31:0 |
| rd_desc | output | 32 | Head record packed descriptor |
| rd_domain | output | 32 | Head record domain word |
| rd_ts_hi | output | 32 | Head record timestamp bits 63:32 |
| pend_raw | output | 1 | Raw pending status |
| pend_masked | output | 1 | Pending status gated by the interrupt enable |
| irq_o | output | 1 | Interrupt request |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is a single cycle in which all ten sources fire while the queue has fewer free slots than requests, because only then do the priority order and the partial drop show together. The stimulus first loads ten records with one simultaneous burst of every source, then fires the same burst again with six slots left, and drains all sixteen records, checking the expected source, port and timestamp of each in turn. The hardware inputs are swept one at a time with all eight lines raised together, so that each enable is shown to pass exactly its own input.

// File: rtl/ts_evq_pkg.sv
// Shared types for the timestamp event queue.
// Assumes a 64-bit time value and the descriptor layout decoded by software.
package ts_evq_pkg;

    typedef enum logic [3:0] {
        EV_SW_PUSH  = 4'd0,
        EV_ROLLOVER = 4'd1,
        EV_HALF_ROLL = 4'd2,
        EV_HW_PUSH  = 4'd3,
        EV_ETH_RX   = 4'd4,
        EV_ETH_TX   = 4'd5,
        EV_COMPARE  = 4'd6,
        EV_HOST_TX  = 4'd7
    } ev_kind_e;

    typedef struct packed {
        logic [63:0] ts;
        logic [4:0]  port;
        ev_kind_e    kind;
        logic [3:0]  msg;
        logic [15:0] seq;
        logic [7:0]  domain;
    } ev_rec_t;

    // Packs the descriptor word in the layout software decodes.
    function automatic logic [31:0] pack_desc(input ev_rec_t r);
        return {3'b000, r.port, r.kind, r.msg, r.seq};
    endfunction

endpackage

// File: rtl/ts_evq_edge.sv
// Rising-edge detector for the hardware push inputs.
// Assumes inputs are already synchronized to clk. An input that is high
// when reset releases does not count as an edge, since the previous value
// is tracked during reset as well.
module ts_evq_edge #(
    parameter int N_HW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_HW-1:0] hw_in,
    input  logic [N_HW-1:0] hw_en,
    output logic [N_HW-1:0] rise
);

    logic [N_HW-1:0] prev_q;

    // Track the previous level of every input, in and out of reset.
    always_ff @(posedge clk) begin
        prev_q <= hw_in;
    end

    // An edge counts only on an enabled input.
    always_comb begin
        rise = hw_in & ~prev_q & hw_en;
    end

    for (genvar k = 0; k < N_HW; k++) begin : g_chk
        AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            rise[k] |-> (hw_in[k] && !$past(hw_in[k]) && hw_en[k])); // R6
    end

endmodule

// File: rtl/ts_evq_collect.sv
// Builds one candidate record per source and gives each active source its
// slot offset, counting only active sources of higher priority.
// Priority (lowest index first): software push, hardware inputs, Ethernet.
// Assumes N_HW <= 31 so that port k+1 fits the 5-bit port field.
module ts_evq_collect
    import ts_evq_pkg::*;
#(
    parameter int N_HW  = 8,
    parameter int NSRC  = N_HW + 2,
    parameter int SRC_W = $clog2(NSRC + 1)
) (
    input  logic [63:0]      ts_now,
    input  logic             sw_push,
    input  logic [N_HW-1:0]  rise,
    input  logic             cfg_rx_ts_en,
    input  logic             eth_valid,
    input  logic             eth_is_tx,
    input  logic [3:0]       eth_msg_type,
    input  logic [15:0]      eth_seq_id,
    input  logic [4:0]       eth_port,
    input  logic [7:0]       eth_domain,
    output logic [NSRC-1:0]  act,
    output ev_rec_t          recs [NSRC],
    output logic [SRC_W-1:0] off  [NSRC]
);

    localparam int ETH_IDX = NSRC - 1;

    logic [SRC_W-1:0] run;

    // Form the request vector and the record each source would store.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            recs[i]    = '0;
            recs[i].ts = ts_now;
        end
        act            = '0;
        act[0]         = sw_push;
        recs[0].kind   = EV_SW_PUSH;
        for (int k = 0; k < N_HW; k++) begin
            act[k+1]       = rise[k];
            recs[k+1].kind = EV_HW_PUSH;
            recs[k+1].port = 5'(k + 1);
        end
        act[ETH_IDX]           = eth_valid && (eth_is_tx || cfg_rx_ts_en);
        recs[ETH_IDX].kind     = eth_is_tx ? EV_ETH_TX : EV_ETH_RX;
        recs[ETH_IDX].port     = eth_port;
        recs[ETH_IDX].msg      = eth_msg_type;
        recs[ETH_IDX].seq      = eth_seq_id;
        recs[ETH_IDX].domain   = eth_domain;
    end

    // Running count of higher-priority requests gives each source its slot.
    always_comb begin
        run = '0;
        for (int i = 0; i < NSRC; i++) begin
            off[i] = run;
            run    = run + SRC_W'(act[i]);
        end
    end

endmodule

// File: rtl/ts_evq_store.sv
// Circular record store with multi-write per cycle and single pop.
// Assumes DEPTH is a power of two. Space is judged on the occupancy at the
// start of the cycle; a pop in the same cycle frees its slot for the next.
module ts_evq_store
    import ts_evq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NSRC  = 10,
    parameter int SRC_W = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  act,
    input  ev_rec_t          recs [NSRC],
    input  logic [SRC_W-1:0] off  [NSRC],
    input  logic             pop_strobe,
    output ev_rec_t          head,
    output logic             pend,
    output logic             overflow
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    ev_rec_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free;
    logic [CNT_W-1:0] nacc;
    logic [SRC_W-1:0] nact;
    logic             pop_fire;
    logic             drop;

    // Space bookkeeping for this cycle's requests.
    always_comb begin
        nact     = off[NSRC-1] + SRC_W'(act[NSRC-1]);
        free     = CNT_W'(DEPTH) - count;
        nacc     = (int'(nact) < int'(free)) ? CNT_W'(nact) : free;
        drop     = int'(nact) > int'(free);
        pop_fire = pop_strobe && (count != '0);
    end

    // Write every active source that still finds a free slot.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                if (act[i] && (int'(off[i]) < int'(free))) begin
                    mem[wr_ptr + PTR_W'(off[i])] <= recs[i];
                end
            end
        end
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            wr_ptr   <= wr_ptr + PTR_W'(nacc);
            rd_ptr   <= rd_ptr + PTR_W'(pop_fire);
            count    <= count + nacc - CNT_W'(pop_fire);
            overflow <= overflow | drop;
        end
    end

    // Present the head record, or zeros when empty.
    always_comb begin
        pend = (count != '0);
        head = pend ? mem[rd_ptr] : '0;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !pop_strobe) |=> (count == CNT_W'(DEPTH))); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
    AST_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_strobe && count == CNT_W'(1) && act == '0) |=> !pend); // R5
    AST_PUSH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0) |=> pend); // R5

endmodule

// File: rtl/ts_event_queue.sv
// Timestamp event queue top: hardware edge detection, source collection,
// record store and the read-word / status view seen by software.
// Assumes hardware inputs are synchronous and ts_now is the running time.
module ts_event_queue
    import ts_evq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N_HW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [63:0]     ts_now,
    input  logic            cfg_rx_ts_en,
    input  logic [N_HW-1:0] cfg_hw_en,
    input  logic            cfg_irq_en,
    input  logic            sw_push,
    input  logic [N_HW-1:0] hw_push_in,
    input  logic            eth_valid,
    input  logic            eth_is_tx,
    input  logic [3:0]      eth_msg_type,
    input  logic [15:0]     eth_seq_id,
    input  logic [4:0]      eth_port,
    input  logic [7:0]      eth_domain,
    input  logic            pop_strobe,
    output logic [31:0]     rd_ts_lo,
    output logic [31:0]     rd_desc,
    output logic [31:0]     rd_domain,
    output logic [31:0]     rd_ts_hi,
    output logic            pend_raw,
    output logic            pend_masked,
    output logic            irq_o,
    output logic            overflow_o
);

    localparam int NSRC  = N_HW + 2;
    localparam int SRC_W = $clog2(NSRC + 1);

    logic [N_HW-1:0]  rise;
    logic [NSRC-1:0]  act;
    ev_rec_t          recs [NSRC];
    logic [SRC_W-1:0] off  [NSRC];
    ev_rec_t          head;

    ts_evq_edge #(.N_HW(N_HW)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_in (hw_push_in),
        .hw_en (cfg_hw_en),
        .rise  (rise)
    );

    ts_evq_collect #(.N_HW(N_HW), .NSRC(NSRC), .SRC_W(SRC_W)) u_collect (
        .ts_now       (ts_now),
        .sw_push      (sw_push),
        .rise         (rise),
        .cfg_rx_ts_en (cfg_rx_ts_en),
        .eth_valid    (eth_valid),
        .eth_is_tx    (eth_is_tx),
        .eth_msg_type (eth_msg_type),
        .eth_seq_id   (eth_seq_id),
        .eth_port     (eth_port),
        .eth_domain   (eth_domain),
        .act          (act),
        .recs         (recs),
        .off          (off)
    );

    ts_evq_store #(.DEPTH(DEPTH), .NSRC(NSRC), .SRC_W(SRC_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .recs       (recs),
        .off        (off),
        .pop_strobe (pop_strobe),
        .head       (head),
        .pend       (pend_raw),
        .overflow   (overflow_o)
    );

    // Software view of the head record and gated status.
    always_comb begin
        rd_ts_lo    = head.ts[31:0];
        rd_ts_hi    = head.ts[63:32];
        rd_desc     = pack_desc(head);
        rd_domain   = {24'h0, head.domain};
        pend_masked = pend_raw && cfg_irq_en;
        irq_o       = pend_masked;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cfg_irq_en && pend_raw)); // R7
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_raw |-> (rd_desc == 32'h0 && rd_ts_lo == 32'h0)); // R11

endmodule

// File: tb/ts_event_queue_bench.sv
`timescale 1ns/100ps
module ts_event_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] ts_now;
    logic        cfg_rx_ts_en;
    logic [7:0]  cfg_hw_en;
    logic        cfg_irq_en;
    logic        sw_push;
    logic [7:0]  hw_push_in;
    logic        eth_valid;
    logic        eth_is_tx;
    logic [3:0]  eth_msg_type;
    logic [15:0] eth_seq_id;
    logic [4:0]  eth_port;
    logic [7:0]  eth_domain;
    logic        pop_strobe;
    logic [31:0] rd_ts_lo, rd_desc, rd_domain, rd_ts_hi;
    logic        pend_raw, pend_masked, irq_o, overflow_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ts_event_queue u_ts_event_queue (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now),
        .cfg_rx_ts_en(cfg_rx_ts_en), .cfg_hw_en(cfg_hw_en), .cfg_irq_en(cfg_irq_en),
        .sw_push(sw_push), .hw_push_in(hw_push_in),
        .eth_valid(eth_valid), .eth_is_tx(eth_is_tx), .eth_msg_type(eth_msg_type),
        .eth_seq_id(eth_seq_id), .eth_port(eth_port), .eth_domain(eth_domain),
        .pop_strobe(pop_strobe),
        .rd_ts_lo(rd_ts_lo), .rd_desc(rd_desc), .rd_domain(rd_domain), .rd_ts_hi(rd_ts_hi),
        .pend_raw(pend_raw), .pend_masked(pend_masked), .irq_o(irq_o), .overflow_o(overflow_o)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    // Expected descriptor word: seq 15:0, msg 19:16, type 23:20, port 28:24 (R2).
    function automatic logic [31:0] exp_desc(input int kind, input int port,
                                             input int msg, input int seq);
        return (32'(port) << 24) | (32'(kind) << 20) | (32'(msg) << 16) | 32'(seq);
    endfunction

    task automatic check_head(input logic [63:0] ts, input int kind, input int port,
                              input int msg, input int seq, input int dom, input string what);
        check({32'h0, rd_ts_lo}, {32'h0, ts[31:0]}, {what, " ts_lo"});
        check({32'h0, rd_ts_hi}, {32'h0, ts[63:32]}, {what, " ts_hi"});
        check({32'h0, rd_desc}, {32'h0, exp_desc(kind, port, msg, seq)}, {what, " desc"});
        check({32'h0, rd_domain}, 64'(dom), {what, " domain"});
    endtask

    task automatic pop_one;
        pop_strobe = 1'b1;
        tick();
        pop_strobe = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] base;
        rst_n = 1'b0; ts_now = 64'h0; cfg_rx_ts_en = 1'b0; cfg_hw_en = 8'h00;
        cfg_irq_en = 1'b0; sw_push = 1'b0; hw_push_in = 8'h00; eth_valid = 1'b0;
        eth_is_tx = 1'b0; eth_msg_type = 4'h0; eth_seq_id = 16'h0; eth_port = 5'h0;
        eth_domain = 8'h0; pop_strobe = 1'b0;
        #1;
        do_reset();

        // Reset state (R5, R9, R11)
        check(64'(pend_raw), 0, "R5 reset pending");
        check(64'(overflow_o), 0, "R9 reset overflow");
        check_head(64'h0, 0, 0, 0, 0, 0, "R11 empty head");

        // Pop on empty is ignored (R5)
        pop_one();
        check(64'(pend_raw), 0, "R5 pop on empty");

        // Software push and interrupt gating (R3, R4, R7)
        ts_now = 64'h1234_5678_9ABC_DEF0;
        sw_push = 1'b1;
        tick();
        sw_push = 1'b0;
        check(64'(pend_raw), 1, "R5 pending after push");
        check(64'(irq_o), 0, "R7 irq masked off");
        check(64'(pend_masked), 0, "R7 masked status off");
        check_head(64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0, 0, "R4 sw push record");
        cfg_irq_en = 1'b1;
        #1;
        check(64'(irq_o), 1, "R7 irq enabled");
        check(64'(pend_masked), 1, "R7 masked status on");
        pop_one();
        check(64'(pend_raw), 0, "R5 pop empties");
        check(64'(irq_o), 0, "R7 irq clears when empty");
        cfg_irq_en = 1'b0;

        // Hardware inputs: each enable passes only its own input (R6)
        for (int k = 0; k < 8; k++) begin
            cfg_hw_en = 8'(1 << k);
            ts_now = 64'h0000_0007_0000_0000 + 64'(k);
            hw_push_in = 8'hFF;
            tick();
            tick();
            check_head(64'h0000_0007_0000_0000 + 64'(k), 3, k + 1, 0, 0, 0, "R6 hw edge record");
            pop_one();
            check(64'(pend_raw), 0, "R6 held input yields one record");
            hw_push_in = 8'h00;
            tick();
        end
        // All inputs disabled: edges ignored (R6)
        cfg_hw_en = 8'h00;
        hw_push_in = 8'hFF;
        tick();
        check(64'(pend_raw), 0, "R6 disabled inputs ignored");
        hw_push_in = 8'h00;
        tick();

        // Receive gating and transmit records (R8, R2, R3, R4)
        ts_now = 64'hAAAA_0000_0000_0001;
        eth_valid = 1'b1; eth_is_tx = 1'b0; eth_msg_type = 4'h3;
        eth_seq_id = 16'hBEEF; eth_port = 5'd17; eth_domain = 8'hC5;
        tick();
        eth_valid = 1'b0;
        check(64'(pend_raw), 0, "R8 receive ignored when disabled");
        eth_valid = 1'b1; eth_is_tx = 1'b1;
        tick();
        eth_valid = 1'b0;
        check_head(64'hAAAA_0000_0000_0001, 5, 17, 3, 16'hBEEF, 8'hC5, "R8 transmit record");
        pop_one();
        cfg_rx_ts_en = 1'b1;
        ts_now = 64'hBBBB_0000_0000_0002;
        eth_valid = 1'b1; eth_is_tx = 1'b0; eth_msg_type = 4'hF;
        eth_seq_id = 16'h0001; eth_port = 5'd31; eth_domain = 8'hFF;
        tick();
        eth_valid = 1'b0;
        check_head(64'hBBBB_0000_0000_0002, 4, 31, 15, 1, 8'hFF, "R2 receive record");
        pop_one();
        check(64'(pend_raw), 0, "R5 empty after receive pop");

        // Fill to depth, then one more is dropped (R1, R9)
        base = 64'h0000_0100_0000_0000;
        sw_push = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ts_now = base + 64'(i);
            tick();
        end
        check(64'(overflow_o), 0, "R9 no overflow at exactly full");
        ts_now = base + 64'd99;
        tick();
        sw_push = 1'b0;
        check(64'(overflow_o), 1, "R9 overflow after drop");
        for (int i = 0; i < 16; i++) begin
            check({32'h0, rd_ts_lo}, base[31:0] + 64'(i), "R1 fifo order after drop");
            pop_one();
        end
        check(64'(pend_raw), 0, "R1 sixteen records only");
        check(64'(overflow_o), 1, "R9 overflow sticky");

        // Simultaneous sources with priority and partial drop (R10)
        do_reset();
        check(64'(overflow_o), 0, "R9 overflow cleared by reset");
        cfg_hw_en = 8'hFF; cfg_rx_ts_en = 1'b1;
        eth_is_tx = 1'b0; eth_msg_type = 4'h2; eth_seq_id = 16'h4242;
        eth_port = 5'd9; eth_domain = 8'h11;
        ts_now = 64'h0000_00A0_0000_0000;
        sw_push = 1'b1; hw_push_in = 8'hFF; eth_valid = 1'b1;
        tick();
        sw_push = 1'b0; hw_push_in = 8'h00; eth_valid = 1'b0;
        tick();
        check(64'(overflow_o), 0, "R10 ten fit without overflow");
        ts_now = 64'h0000_00B0_0000_0000;
        sw_push = 1'b1; hw_push_in = 8'hFF; eth_valid = 1'b1;
        tick();
        sw_push = 1'b0; hw_push_in = 8'h00; eth_valid = 1'b0;
        tick();
        check(64'(overflow_o), 1, "R10 second burst overflows");
        for (int n = 0; n < 16; n++) begin
            logic [63:0] ets;
            int idx;
            ets = (n < 10) ? 64'h0000_00A0_0000_0000 : 64'h0000_00B0_0000_0000;
            idx = (n < 10) ? n : n - 10;
            if (idx == 0)
                check_head(ets, 0, 0, 0, 0, 0, "R10 slot software push");
            else if (idx <= 8)
                check_head(ets, 3, idx, 0, 0, 0, "R10 slot hardware input");
            else
                check_head(ets, 4, 9, 2, 16'h4242, 8'h11, "R10 slot ethernet");
            pop_one();
        end
        check(64'(pend_raw), 0, "R10 lowest priority dropped");
        check_head(64'h0, 0, 0, 0, 0, 0, "R11 empty head after drain");

        finish_run();
    end

endmodule